// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous host and an asynchronous static RAM that holds 2048 bytes and is accessed through chip-enable, write-enable and output-enable strobes, all active low. The host raises a one-cycle request with a write flag, an address and a write byte. The controller turns that request into a strobe sequence whose lengths are given as parameters in clock cycles. These parameters come from the chosen speed grade of the memory: access time, write pulse width, data hold and cycle time. The memory data bus is bidirectional. The controller provides a separate output byte, an input byte and a drive enable for the pad's tri-state buffer.

A read lowers chip-enable and output-enable while write-enable stays high. The read byte is captured on the last cycle of the access window and is returned with a one-cycle done pulse. A write lowers chip-enable and write-enable together and drives the byte for the whole pulse. It ends the write by raising write-enable first. Chip-enable and the driven byte are then held for a hold interval, so the write is always terminated by write-enable. Output-enable is never low while the controller drives the bus or while write-enable is low. After every access the controller waits out the cycle time. Requests that arrive while an access is in progress are ignored.

The states are ST_IDLE, ST_READ, ST_WSTROBE, ST_WHOLD and ST_RECOVER. The transitions are:
- ST_IDLE goes to ST_READ or ST_WSTROBE when a request arrives.
- ST_READ goes to ST_RECOVER when the access window expires, which captures the read byte and raises done.
- ST_WSTROBE goes to ST_WHOLD when the pulse width expires, which raises write-enable.
- ST_WHOLD goes to ST_RECOVER when the hold expires, which releases the bus and raises done.
- ST_RECOVER goes to ST_IDLE when the cycle-time counter reaches zero.

The parameters must satisfy RD_CYC + 1 < CYC_CYC, WP_CYC + HOLD_CYC + 1 < CYC_CYC and HOLD_CYC >= 1.

Top module: `nvs_sram_ctrl`

## Requirements
- R1: While rst_n is low, the controller holds all three strobes high, the drive enable low, done low and rsp_rdata at 0.
- R2: A read request accepted at clock edge E holds sram_ce_n and sram_oe_n low, with sram_we_n high, for exactly RD_CYC cycles after E.
- R3: For a read accepted at edge E, the controller takes the byte on sram_dq_in at edge E+RD_CYC, and from then on rsp_rdata shows that byte. rsp_rdata keeps its value until the next read completes.
- R4: A write request accepted at edge E holds sram_ce_n and sram_we_n low together for exactly WP_CYC cycles. During that time the request byte is driven on sram_dq_out with sram_dq_oe high, and sram_oe_n stays high.
- R5: sram_we_n rises first. sram_ce_n then stays low, and the same byte stays driven, for HOLD_CYC more cycles. The write therefore always ends on the write-enable edge.
- R6: sram_dq_oe is high only during the write pulse and its hold. It is low in the cycle before sram_oe_n falls and in every cycle that sram_oe_n is low.
- R7: After a request is accepted at edge E, the next request can be accepted no earlier than edge E+CYC_CYC. A request raised in between causes no strobe, no done and no memory change.
- R8: rsp_done is high for exactly one cycle per accepted request. For a read this is at E+RD_CYC, and for a write at E+WP_CYC+HOLD_CYC.
- R9: sram_addr takes the request address at acceptance and stays unchanged while any strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, taken only in ST_IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DATA_W | Byte to drive onto the memory bus |
| sram_dq_oe | output | 1 | Tri-state drive enable for the bus |
| sram_dq_in | input | DATA_W | Byte read from the memory bus |

## Verification
Two events can fall in the same cycle: the controller's return to ST_IDLE at the end of the cycle time, and a host request that has been held high since the previous access began. The bench holds req_valid high across whole accesses, both with a changing address and data and with a steady stream of reads. The reference model then decides, edge by edge, which edge accepts the request. The bench compares every strobe, the drive enable, done and the returned byte against that model on every cycle. A bench memory model returns a poison byte for any read window shorter than the access time, and it commits a write only at the end of the strobe overlap. As a result, a request accepted a cycle early or late shows up both as a strobe mismatch and as wrong data.

// File: rtl/nvs_ctrl_pkg.sv
package nvs_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSTROBE,
        ST_WHOLD,
        ST_RECOVER
    } ctrl_state_e;

endpackage

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nvs_bus_latch.sv
module nvs_bus_latch #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req,
    input  logic              cap_rd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] in_rdq,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (cap_req) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_rd) begin
            rdata_q <= in_rdq;
        end
    end

endmodule

// File: rtl/nvs_sram_ctrl.sv
module nvs_sram_ctrl
    import nvs_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RD_CYC   = 10,
    parameter int unsigned WP_CYC   = 8,
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned CYC_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int unsigned CNT_W = $clog2(CYC_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] CYC_LD  = CNT_W'(CYC_CYC - 1);

    ctrl_state_e      state_q, state_d;
    logic             ph_load, ph_zero;
    logic [CNT_W-1:0] ph_val;
    logic             cy_load, cy_zero;
    logic             accept, finish, rd_capture;

    // Phase timer: length of the current strobe phase.
    nvs_cycle_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    // Cycle timer: minimum spacing between accepted requests.
    nvs_cycle_timer #(.CNT_W(CNT_W)) u_cycle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cy_load),
        .load_val (CYC_LD),
        .zero     (cy_zero)
    );

    nvs_bus_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_req  (accept),
        .cap_rd   (rd_capture),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_rdq   (sram_dq_in),
        .addr_q   (sram_addr),
        .wdata_q  (sram_dq_out),
        .rdata_q  (rsp_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        ph_load    = 1'b0;
        ph_val     = '0;
        cy_load    = 1'b0;
        accept     = 1'b0;
        finish     = 1'b0;
        rd_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    cy_load = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = req_write ? WP_LD : RD_LD;
                    state_d = req_write ? ST_WSTROBE : ST_READ;
                end
            end
            ST_READ: begin
                if (ph_zero) begin
                    finish     = 1'b1;
                    rd_capture = 1'b1;
                    state_d    = ST_RECOVER;
                end
            end
            ST_WSTROBE: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    ph_val  = HOLD_LD;
                    state_d = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                if (ph_zero) begin
                    finish  = 1'b1;
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (cy_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered strobes, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            rsp_done   <= 1'b0;
        end else begin
            rsp_done   <= finish;
            sram_ce_n  <= !(state_d inside {ST_READ, ST_WSTROBE, ST_WHOLD});
            sram_we_n  <= (state_d != ST_WSTROBE);
            sram_oe_n  <= (state_d != ST_READ);
            sram_dq_oe <= (state_d inside {ST_WSTROBE, ST_WHOLD});
        end
    end

endmodule

// File: rtl/nvs_sram_ctrl_chk.sv
module nvs_sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned WP_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              rsp_done
);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!sram_we_n) begin
            if (we_low_cnt != 16'hFFFF) we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    a_r4_we_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= 16'(WP_CYC)));

    a_r5_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe));

    a_r6_no_drive_while_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    a_r6_gap_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> !$past(sram_dq_oe));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

bind nvs_sram_ctrl nvs_sram_ctrl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr),
    .rsp_done   (rsp_done)
);

// File: tb/nvs_sram_ctrl_tb.sv
module nvs_sram_ctrl_tb;

    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int RD   = 10;
    localparam int WP   = 8;
    localparam int HOLD = 1;
    localparam int CYC  = 12;
    localparam int ACC_MIN = 10;   // 100 ns at 10 ns per cycle
    localparam int WP_MIN  = 8;    // 75 ns rounded up

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    nvs_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WP_CYC(WP),
                    .HOLD_CYC(HOLD), .CYC_CYC(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] sram_mem [2048];
    int            acc_cnt = 0;
    bit            p_ov = 1'b0, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    int            ov_cnt = 0;
    logic [AW-1:0] ov_addr = '0;
    logic [DW-1:0] ov_data = '0;

    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n && acc_cnt >= ACC_MIN)
                        ? sram_mem[sram_addr] : 8'hEE;

    always @(negedge clk) begin
        if (cmp_en) begin
            bit ov;
            ov = !sram_ce_n && !sram_we_n;
            if (!sram_oe_n) begin
                chk(sram_we_n, "R2 oe with we", sram_we_n, 1);
                chk(!sram_dq_oe, "R6 drive with oe", sram_dq_oe, 0);
                if (p_oe_n) chk(!p_dq_oe, "R6 gap before oe", p_dq_oe, 0);
            end
            if (ov) begin
                if (!p_ov) begin
                    ov_cnt  = 0;
                    ov_addr = sram_addr;
                    ov_data = sram_dq_out;
                end
                ov_cnt++;
                chk(sram_addr == ov_addr, "R9 addr in write", sram_addr, ov_addr);
                chk(sram_dq_oe && sram_dq_out == ov_data, "R4 data in write", sram_dq_out, ov_data);
            end else if (p_ov) begin
                chk(ov_cnt >= WP_MIN, "R4 pulse width", ov_cnt, WP_MIN);
                chk(sram_dq_oe && sram_dq_out == ov_data, "R5 hold after we", sram_dq_out, ov_data);
                chk(sram_we_n && !sram_ce_n, "R5 ended by we", sram_ce_n, 0);
                sram_mem[ov_addr] = ov_data;
            end
            p_ov    = ov;
            p_oe_n  = sram_oe_n;
            p_dq_oe = sram_dq_oe;
            if (!sram_ce_n && !sram_oe_n) acc_cnt++;
            else acc_cnt = 0;
        end
    end

    // ---------------- reference model ----------------
    logic [DW-1:0] ref_mem [2048];
    bit            m_busy = 1'b0, m_wr = 1'b0;
    int            m_t = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy  = 1'b0;
            m_t     = 0;
            m_rdata = '0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == CYC) m_busy = 1'b0;
            else if (m_t == (m_wr ? WP + HOLD : RD)) begin
                if (m_wr) ref_mem[m_addr] = m_data;
                else m_rdata = ref_mem[m_addr];
            end
        end else if (req_valid) begin
            m_busy = 1'b1;
            m_t    = 0;
            m_wr   = req_write;
            m_addr = req_addr;
            m_data = req_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            bit rd_act, wr_act, hd_act, e_done;
            rd_act = m_busy && !m_wr && m_t < RD;
            wr_act = m_busy && m_wr && m_t < WP;
            hd_act = m_busy && m_wr && m_t >= WP && m_t < WP + HOLD;
            e_done = m_busy && m_t == (m_wr ? WP + HOLD : RD);
            chk(sram_ce_n == !(rd_act || wr_act || hd_act), "R2 ce_n", sram_ce_n, !(rd_act || wr_act || hd_act));
            chk(sram_oe_n == !rd_act, "R2 oe_n", sram_oe_n, !rd_act);
            chk(sram_we_n == !wr_act, "R4 we_n", sram_we_n, !wr_act);
            chk(sram_dq_oe == (wr_act || hd_act), "R6 dq_oe", sram_dq_oe, wr_act || hd_act);
            chk(rsp_done == e_done, "R8 done", rsp_done, e_done);
            chk(rsp_rdata == m_rdata, "R3 rdata", rsp_rdata, m_rdata);
            if (rd_act || wr_act || hd_act)
                chk(sram_addr == m_addr, "R9 addr", sram_addr, m_addr);
            if (wr_act || hd_act)
                chk(sram_dq_out == m_data, "R4 dq_out", sram_dq_out, m_data);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wait_idle();
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            sram_mem[i] = '0;
            ref_mem[i]  = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        chk(!sram_dq_oe && !rsp_done, "R1 drive/done", {sram_dq_oe, rsp_done}, 0);
        chk(rsp_rdata == 0, "R1 rdata", rsp_rdata, 0);
        rst_n  = 1'b1;
        cmp_en = 1'b1;

        // write then read back, mid and boundary addresses
        send(1'b1, 11'h005, 8'h3C);
        send(1'b0, 11'h005, 8'h00);
        send(1'b1, 11'h000, 8'hA1);
        send(1'b1, 11'h7FF, 8'h5E);
        send(1'b0, 11'h7FF, 8'h00);
        send(1'b0, 11'h000, 8'h00);
        send(1'b0, 11'h123, 8'h00);   // never written: reads 0

        // R7: request held through a busy write with new address and data
        wait_idle();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h040; req_wdata = 8'h77;
        @(negedge clk);
        req_addr = 11'h041; req_wdata = 8'h99;
        repeat (CYC - 1) @(negedge clk);
        req_valid = 1'b0;
        send(1'b0, 11'h041, 8'h00);
        wait_idle();
        chk(rsp_rdata == 8'h00, "R7 ignored write left memory", rsp_rdata, 0);
        send(1'b0, 11'h040, 8'h00);
        wait_idle();
        chk(rsp_rdata == 8'h77, "R7 accepted write", rsp_rdata, 8'h77);

        // R7: back-to-back reads with request held high
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h7FF;
        begin
            int falls = 0;
            bit prev_ce = 1'b1;
            for (int k = 0; k < 3 * CYC + 2; k++) begin
                @(negedge clk);
                if (prev_ce && !sram_ce_n) falls++;
                prev_ce = sram_ce_n;
            end
            chk(falls == 3, "R7 spacing under held request", falls, 3);
        end
        req_valid = 1'b0;
        wait_idle();
        chk(rsp_rdata == 8'h5E, "R3 held request read", rsp_rdata, 8'h5E);

        // write immediately followed by a read of the same byte
        send(1'b1, 11'h2AA, 8'hC3);
        send(1'b0, 11'h2AA, 8'h00);
        wait_idle();
        chk(rsp_rdata == 8'hC3, "R3 read after write", rsp_rdata, 8'hC3);
        repeat (4) @(negedge clk);
        done_flag = 1'b1;
        summary();
    end

    initial begin
        #200000;
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

endmodule